// File: doc/BRIEF.md
# Configurable Eight-Pin I/O Port

This block is one byte-wide general-purpose I/O port with a small register bus. The bus reaches four registers. Two of them hold data: the pin input value and the output latch. The other two give indirect access to configuration. A selector register holds a code, and a window register reads or writes whichever configuration bank that code names. There are five banks, each with one bit per pin: direction, alternate-function enable, open-drain mode, high-drive enable and wake-from-stop enable.

Pin levels pass through a two-stage synchronizer before they reach the input register and the edge detectors. Each pin raises a one-cycle interrupt pulse. A pin marked as an any-edge pin pulses on both transitions. Every other pin pulses on one fixed polarity. The per-pin output value and output enable come from the direction, open-drain and output-latch settings. On a port built with alternate functions, a pin with its alternate bit set takes its value and enable from a peripheral instead. The high-drive and wake banks are brought out as plain per-pin controls for the pad ring and the power controller.

Top module: `gpio_port`

## Requirements
- R1: The bus register offsets are 0 = selector, 1 = window, 2 = input value, 3 = output latch. A write to offset 2 changes no state. Reads have no side effects.
- R2: A read of the window returns the bank named by the selector, and a write to the window updates only that bank. The selector reads back as written.
- R3: The bank codes are 0x01 direction, 0x02 alternate function, 0x03 open-drain, 0x04 high drive and 0x05 wake enable. Any other selector value reads 0x00 through the window and ignores window writes.
- R4: After reset the direction bank is 0xFF. Every other bank, the output latch and the selector are 0x00.
- R5: Direction bit 1 makes the pin an input with `pin_oe` low. Direction bit 0 makes it an output that drives the output latch bit with `pin_oe` high.
- R6: An output pin with its open-drain bit set drives 0 with `pin_oe` high when its latch bit is 0. When its latch bit is 1 it deasserts `pin_oe`.
- R7: On a port built with alternate functions, a pin whose alternate bit is 1 takes `pin_out` from `alt_out` and `pin_oe` from `alt_oe`, whatever the other banks hold.
- R8: On a port built without alternate functions, the alternate bank still stores and reads back, but it has no effect on `pin_out` or `pin_oe`.
- R9: The input register shows the value that `pin_in` had two rising clock edges earlier.
- R10: A single-edge pin gives a one-cycle `irq` pulse when its synchronized level makes the transition chosen by its polarity bit (1 = rising, 0 = falling). With the default masks, pins 0 and 2 fire on rising edges and pins 1 and 3 on falling edges.
- R11: An any-edge pin gives a one-cycle `irq` pulse on every change of its synchronized level. With the default masks these are pins 4 to 7.
- R12: `hi_drive` and `wake_en` always equal the high-drive and wake-enable banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Peripheral output values for alternate-function pins |
| alt_oe | input | 8 | Peripheral output enables for alternate-function pins |
| hi_drive | output | 8 | Per-pin high-drive control |
| wake_en | output | 8 | Per-pin wake-from-stop enable |
| irq | output | 8 | Per-pin edge interrupt pulses |

## Verification
Register writes take effect on the clock edge that samples them. The pin controls and read data are combinational from the registers, so they are due in the cycle right after the write. An input change appears in the input register after two rising edges, and its interrupt pulse is visible during that same cycle and gone one cycle later. The bench drives inputs on the falling edge and advances its reference model just after each rising edge. It compares every output at the next falling edge, so each result is sampled in the exact cycle it is due.

// File: rtl/gpio_port_pkg.sv
// Shared constants for the I/O port: bus register offsets and the codes
// that pick a configuration bank through the indirect window.
package gpio_port_pkg;

    // Bus register offsets; the bench and software depend on this order.
    typedef enum logic [1:0] {
        REG_SEL  = 2'd0,
        REG_WIN  = 2'd1,
        REG_IN   = 2'd2,
        REG_OUT  = 2'd3
    } bus_reg_e;

    // Configuration bank codes seen through the window register.
    localparam int BANK_DIR  = 1;
    localparam int BANK_ALT  = 2;
    localparam int BANK_ODR  = 3;
    localparam int BANK_HDR  = 4;
    localparam int BANK_WAKE = 5;
    localparam int NUM_BANKS = 5;

endpackage

// File: rtl/gpio_port_sync.sv
// Two-stage synchronizer for asynchronous pad levels.
// Assumes the pads are sampled only here; output lags the pad by two edges.
module gpio_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_q;

    // Shift the pad levels through both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    // Count edges since reset so the latency check only looks at valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd3)
            warm_q <= warm_q + 2'd1;
    end

    assign sync_out = stage2_q;

    // R9
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_port_edge.sv
// Per-pin edge detector producing one-cycle pulses.
// Assumes lvl is already synchronous; ANY_MASK pins fire on both edges,
// the rest fire on the polarity given by RISE_MASK (1 = rising).
module gpio_port_edge #(
    parameter int         W         = 8,
    parameter logic [W-1:0] ANY_MASK  = '0,
    parameter logic [W-1:0] RISE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] pulse
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic went_up;
        logic went_down;
        assign went_up   =  lvl[i] & ~prev_q[i];
        assign went_down = ~lvl[i] &  prev_q[i];

        if (ANY_MASK[i]) begin : g_any
            assign pulse[i] = went_up | went_down;
        end else if (RISE_MASK[i]) begin : g_rise
            assign pulse[i] = went_up;
            // R10
            rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pulse[i] |=> !pulse[i]);
        end else begin : g_fall
            assign pulse[i] = went_down;
            // R10
            fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pulse[i] |=> !pulse[i]);
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Bus-visible registers: selector, indirect window, input view and output
// latch, plus the five configuration banks behind the window.
// Assumes single-cycle writes and a combinational read path.
module gpio_port_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] in_val,
    output logic [W-1:0] bus_rdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] alt_q,
    output logic [W-1:0] odr_q,
    output logic [W-1:0] hdr_q,
    output logic [W-1:0] wake_q,
    output logic [W-1:0] out_q
);
    import gpio_port_pkg::*;

    logic [W-1:0] sel_q;
    logic [W-1:0] bank_q [1:NUM_BANKS];
    logic         win_wr;
    logic         any_hit;

    assign win_wr = bus_wr && (bus_addr == REG_WIN);

    // Selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && bus_addr == REG_SEL)
            sel_q <= bus_wdata;
    end

    // Output latch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (bus_wr && bus_addr == REG_OUT)
            out_q <= bus_wdata;
    end

    // One storage bank per code; only direction resets to all-inputs.
    for (genvar k = 1; k <= NUM_BANKS; k++) begin : g_bank
        localparam logic [W-1:0] RST_VAL = (k == BANK_DIR) ? '1 : '0;
        // Write the bank when the selector names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[k] <= RST_VAL;
            else if (win_wr && sel_q == W'(k))
                bank_q[k] <= bus_wdata;
        end
    end

    assign dir_q  = bank_q[BANK_DIR];
    assign alt_q  = bank_q[BANK_ALT];
    assign odr_q  = bank_q[BANK_ODR];
    assign hdr_q  = bank_q[BANK_HDR];
    assign wake_q = bank_q[BANK_WAKE];

    // Read mux: window returns the selected bank or zero for unused codes.
    always_comb begin
        bus_rdata = '0;
        any_hit   = 1'b0;
        unique case (bus_addr)
            REG_SEL: bus_rdata = sel_q;
            REG_WIN: begin
                for (int k = 1; k <= NUM_BANKS; k++) begin
                    if (sel_q == W'(k)) begin
                        bus_rdata = bank_q[k];
                        any_hit   = 1'b1;
                    end
                end
            end
            REG_IN:  bus_rdata = in_val;
            REG_OUT: bus_rdata = out_q;
            default: bus_rdata = '0;
        endcase
    end

    // R3
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && (sel_q == '0 || sel_q > W'(NUM_BANKS))) |=>
            ($stable(dir_q) && $stable(alt_q) && $stable(odr_q) &&
             $stable(hdr_q) && $stable(wake_q)));

    // R1
    input_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_IN) |=> ($stable(sel_q) && $stable(out_q)));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && sel_q == W'(BANK_DIR)) |=> (dir_q == $past(bus_wdata)));

    // R3
    unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_WIN && !any_hit) |-> (bus_rdata == '0));

endmodule

// File: rtl/gpio_port.sv
// Top of the I/O port: register block, pad synchronizer, edge detectors
// and the per-pin output/enable selection.
// Assumes one clock domain; HAS_ALT = 0 builds a port with no peripheral muxing.
module gpio_port #(
    parameter int         W         = 8,
    parameter bit         HAS_ALT   = 1'b1,
    parameter logic [W-1:0] ANY_MASK  = 8'hF0,
    parameter logic [W-1:0] RISE_MASK = 8'h05
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] hi_drive,
    output logic [W-1:0] wake_en,
    output logic [W-1:0] irq
);
    logic [W-1:0] in_val;
    logic [W-1:0] dir_q, alt_q, odr_q, out_q;
    logic [W-1:0] alt_eff;

    gpio_port_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_val)
    );

    gpio_port_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_val    (in_val),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .alt_q     (alt_q),
        .odr_q     (odr_q),
        .hdr_q     (hi_drive),
        .wake_q    (wake_en),
        .out_q     (out_q)
    );

    gpio_port_edge #(.W(W), .ANY_MASK(ANY_MASK), .RISE_MASK(RISE_MASK)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (in_val),
        .pulse (irq)
    );

    assign alt_eff = alt_q & {W{HAS_ALT}};

    // Per-pin drive selection: peripheral, open-drain, or push-pull.
    for (genvar i = 0; i < W; i++) begin : g_pad
        always_comb begin
            if (alt_eff[i]) begin
                pin_out[i] = alt_out[i];
                pin_oe[i]  = alt_oe[i];
            end else begin
                pin_out[i] = out_q[i] & ~odr_q[i];
                pin_oe[i]  = ~dir_q[i] & ~(odr_q[i] & out_q[i]);
            end
        end

        // R5
        input_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_q[i] && !alt_eff[i]) |-> !pin_oe[i]);

        // R6
        od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!alt_eff[i] && odr_q[i] && out_q[i]) |-> !pin_oe[i]);

        // R11
        irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (in_val[i] != $past(in_val[i])));
    end

endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] alt_out = 8'h00;
    logic [7:0] alt_oe = 8'h00;
    logic [7:0] rdata_a, pout_a, poe_a, hd_a, wk_a, irq_a;
    logic [7:0] rdata_b, pout_b, poe_b, hd_b, wk_b, irq_b;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pin_in(pin_in),
        .pin_out(pout_a), .pin_oe(poe_a), .alt_out(alt_out), .alt_oe(alt_oe),
        .hi_drive(hd_a), .wake_en(wk_a), .irq(irq_a)
    );

    gpio_port #(.HAS_ALT(1'b0)) u_noalt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin_in),
        .pin_out(pout_b), .pin_oe(poe_b), .alt_out(alt_out), .alt_oe(alt_oe),
        .hi_drive(hd_b), .wake_en(wk_b), .irq(irq_b)
    );

    // Reference model state
    logic [7:0] m_sel, m_out;
    logic [7:0] m_bank [1:5];
    logic [7:0] hist [$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            2'd0: return m_sel;
            2'd1: return (m_sel >= 8'd1 && m_sel <= 8'd5) ? m_bank[m_sel[2:0]] : 8'h00;
            2'd2: return hist[1];
            default: return m_out;
        endcase
    endfunction

    function automatic logic [7:0] exp_pin(input bit has_alt, input bit want_oe);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (has_alt && m_bank[2][i])
                r[i] = want_oe ? alt_oe[i] : alt_out[i];
            else if (want_oe)
                r[i] = !m_bank[1][i] && !(m_bank[3][i] && m_out[i]);
            else
                r[i] = m_out[i] && !m_bank[3][i];
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_irq();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            bit up   = hist[1][i] && !hist[2][i];
            bit down = !hist[1][i] && hist[2][i];
            if (i >= 4) r[i] = up || down;
            else if (i == 0 || i == 2) r[i] = up;
            else r[i] = down;
        end
        return r;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_sel = 8'h00; m_out = 8'h00;
            m_bank[1] = 8'hFF;
            for (int k = 2; k <= 5; k++) m_bank[k] = 8'h00;
        end else if (bus_wr) begin
            case (bus_addr)
                2'd0: m_sel = bus_wdata;
                2'd1: if (m_sel >= 8'd1 && m_sel <= 8'd5) m_bank[m_sel[2:0]] = bus_wdata;
                2'd3: m_out = bus_wdata;
                default: ;
            endcase
        end
        hist.push_front(pin_in);
        void'(hist.pop_back());
    endtask

    // One clock: update model after the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 rdata", rdata_a, exp_rdata());
        chk("R8 rdata noalt", rdata_b, exp_rdata());
        chk("R5 pin_out", pout_a, exp_pin(1'b1, 1'b0));
        chk("R5 pin_oe", poe_a, exp_pin(1'b1, 1'b1));
        chk("R8 pin_out noalt", pout_b, exp_pin(1'b0, 1'b0));
        chk("R8 pin_oe noalt", poe_b, exp_pin(1'b0, 1'b1));
        chk("R12 hi_drive", hd_a, m_bank[4]);
        chk("R12 wake_en", wk_a, m_bank[5]);
        chk("R10 irq", irq_a, exp_irq());
        chk("R11 irq noalt", irq_b, exp_irq());
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_addr = a;
        step();
    endtask

    initial begin
        hist = '{8'h00, 8'h00, 8'h00};
        for (int k = 1; k <= 5; k++) m_bank[k] = 8'h00;
        m_sel = 8'h00; m_out = 8'h00;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R4 reset values
        rd(2'd0); chk("R4 selector", rdata_a, 8'h00);
        rd(2'd3); chk("R4 out latch", rdata_a, 8'h00);
        wr(2'd0, 8'h01); rd(2'd1); chk("R4 direction", rdata_a, 8'hFF);
        chk("R5 all inputs oe", poe_a, 8'h00);
        for (int k = 2; k <= 5; k++) begin
            wr(2'd0, 8'(k)); rd(2'd1); chk("R4 bank zero", rdata_a, 8'h00);
        end

        // R12 / R2 banks through the window
        wr(2'd0, 8'h05); wr(2'd1, 8'h3C); chk("R12 wake", wk_a, 8'h3C);
        wr(2'd0, 8'h04); wr(2'd1, 8'hA5); chk("R12 drive", hd_a, 8'hA5);
        rd(2'd1); chk("R2 window readback", rdata_a, 8'hA5);
        rd(2'd0); chk("R2 selector readback", rdata_a, 8'h04);

        // R3 unused codes
        wr(2'd0, 8'h07); wr(2'd1, 8'hFF); rd(2'd1); chk("R3 unused reads zero", rdata_a, 8'h00);
        wr(2'd0, 8'h00); wr(2'd1, 8'h5A); rd(2'd1); chk("R3 code zero", rdata_a, 8'h00);
        chk("R3 drive kept", hd_a, 8'hA5);
        chk("R3 wake kept", wk_a, 8'h3C);
        wr(2'd0, 8'h01); rd(2'd1); chk("R3 dir kept", rdata_a, 8'hFF);

        // R5 push-pull outputs
        wr(2'd3, 8'h96); wr(2'd0, 8'h01); wr(2'd1, 8'h0F);
        chk("R5 oe", poe_a, 8'hF0);
        chk("R5 out", pout_a, 8'h96);

        // R6 open-drain
        wr(2'd0, 8'h03); wr(2'd1, 8'hC0);
        chk("R6 oe", poe_a, 8'h70);
        chk("R6 out", pout_a, 8'h16);

        // R7 / R8 alternate function
        alt_out = 8'h02; alt_oe = 8'h03;
        wr(2'd0, 8'h02); wr(2'd1, 8'h03);
        chk("R7 oe", poe_a, 8'h73);
        chk("R7 out", pout_a, 8'h16);
        chk("R8 oe noalt", poe_b, 8'h70);
        chk("R8 out noalt", pout_b, 8'h16);
        rd(2'd1); chk("R8 bank stored noalt", rdata_b, 8'h03);
        alt_out = 8'h01; alt_oe = 8'h02; step();
        chk("R7 follow out", pout_a, 8'h15);
        chk("R8 noalt unaffected", pout_b, 8'h16);

        // R1 write to input register ignored
        wr(2'd2, 8'hFF); rd(2'd2); chk("R1 input unchanged", rdata_a, 8'h00);
        rd(2'd3); chk("R1 out latch", rdata_a, 8'h96);
        rd(2'd0); chk("R1 selector", rdata_a, 8'h02);

        // R9 / R10 / R11 edges
        bus_addr = 2'd2;
        pin_in = 8'hFF; step();
        chk("R9 one edge", rdata_a, 8'h00);
        step();
        chk("R9 two edges", rdata_a, 8'hFF);
        chk("R10 R11 rise", irq_a, 8'hF5);
        step();
        chk("R10 pulse ends", irq_a, 8'h00);
        pin_in = 8'h00; step(); step();
        chk("R10 R11 fall", irq_a, 8'hFA);
        step();
        chk("R11 pulse ends", irq_a, 8'h00);
        for (int n = 0; n < 40; n++) begin
            pin_in = (n % 3 == 0) ? 8'h55 : ((n % 3 == 1) ? 8'hAA : 8'(n * 37));
            step();
        end
        pin_in = 8'h00;
        repeat (4) step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule